// File: doc/BRIEF.md
# Rotating-Slot Wide Shared Memory Controller

This block lets sixteen client cores share one memory built from sixteen parallel 32-bit banks. A slot counter hands the whole memory to exactly one client per clock in a fixed rotation. Each client therefore sees its turn once every sixteen clocks at a fixed phase, with no jitter. In its slot the owning client may read or write a byte, a 16-bit word, a 32-bit long, or a full 512-bit block, and a block moves in that one clock.

Because only one client is served at a time, a single row address is shared by every bank. A narrow access enables only the bank picked by the address. A block access enables all sixteen banks on the same row. Each client has its own request port. A client that asserts a request outside its slot sees its stall output high until its slot comes round. Read results appear on one shared data bus, qualified by a per-client valid pulse in the clock after the slot.

The access decode is a per-cycle state, `OP_IDLE`, `OP_RD_NARROW`, `OP_WR_NARROW`, `OP_RD_BLOCK` or `OP_WR_BLOCK`, taken from the owner's valid, write and size inputs. The response path is a registered state machine with three states, `RS_NONE`, `RS_NARROW` and `RS_BLOCK`. It enters `RS_NARROW` after an `OP_RD_NARROW` cycle and `RS_BLOCK` after an `OP_RD_BLOCK` cycle. Every other cycle, including any write or idle slot, leads it to `RS_NONE`. Reset forces `RS_NONE`.

Top module: `hub_slot_mem`

## Requirements
- R1: The slot counter names client 0, 1, … 15 on successive clocks and wraps from 15 to 0. `req_stall[c]` is high exactly when `req_valid[c]` is high and client c is not the current owner.
- R2: When the owner requests a read, `rsp_valid` for that client alone is high in the next clock and `rsp_data` carries the result. Writes never raise `rsp_valid`.
- R3: Size code 0 is byte, 1 is word, 2 is long and 3 is block. A narrow read returns the addressed byte, word or long zero-extended in `rsp_data[31:0]`. The byte lane is given by address bits [1:0]. The bank is given by bits [5:2] and the row by bits [11:6] (the width follows `ROW_W`).
- R4: A byte or word write takes its data from the low 8 or 16 bits of the client's write data. It changes only the addressed bytes of the long.
- R5: A block read returns long i of the addressed row from bank i in `rsp_data[32*i+31:32*i]`. Address bits [5:0] are ignored.
- R6: A block write stores write-data long i into bank i of the addressed row. Address bits [5:0] are ignored.
- R7: A word access ignores address bit 0, and a long access ignores address bits [1:0].
- R8: A narrow access enables exactly one bank. A block access enables all sixteen banks.
- R9: After reset the first owner is client 0, and no `rsp_valid` bit is high while reset is asserted.
- R10: Requests from clients that do not own the current slot have no effect on memory or responses. An owner slot with no request produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | CLIENTS | Request present, one bit per client |
| req_write | input | CLIENTS | 1 = write, 0 = read, per client |
| req_size | input | 2*CLIENTS | Access size code per client (0 byte, 1 word, 2 long, 3 block) |
| req_addr | input | ADDR_W*CLIENTS | Byte address per client |
| req_wdata | input | 512*CLIENTS | Write data per client; narrow data in the low bits |
| req_stall | output | CLIENTS | Request waiting for its slot |
| rsp_valid | output | CLIENTS | Read result valid for that client |
| rsp_data | output | 512 | Shared read result bus |

## Verification
The bench uses the default parameters: sixteen clients, sixteen banks and six row bits. That gives a 4 KB space of 1024 longs. The space is small enough that a full block-write fill sets every location first, and random narrow and block traffic later hits the same longs many times, so partial-byte writes and block reads cross-check each other. Non-owning clients drive random valid requests every cycle, so stall decoding and the rule that non-owners are ignored are exercised in every slot. Directed steps cover misaligned word and long addresses, the top long of memory, and block reads with nonzero low address bits.

// File: rtl/hub_pkg.sv
package hub_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_LONG  = 2'd2,
        SZ_BLOCK = 2'd3
    } xfer_size_e;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_RD_NARROW,
        OP_WR_NARROW,
        OP_RD_BLOCK,
        OP_WR_BLOCK
    } op_e;

    typedef enum logic [1:0] {
        RS_NONE,
        RS_NARROW,
        RS_BLOCK
    } rsp_state_e;

endpackage

// File: rtl/hub_slot_ctr.sv
module hub_slot_ctr #(
    parameter int CLIENTS = 16,
    localparam int SLOT_W = $clog2(CLIENTS)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [SLOT_W-1:0] slot
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(CLIENTS - 1);

    always_ff @(posedge clk) begin
        if (rst)
            slot <= '0;
        else if (slot == LAST)
            slot <= '0;
        else
            slot <= slot + 1'b1;
    end

    // R1: rotation advances by one and wraps at the last client
    a_r1_slot_advance: assert property (@(posedge clk) disable iff (rst)
        (slot != LAST) |=> (slot == $past(slot) + 1'b1));
    a_r1_slot_wrap: assert property (@(posedge clk) disable iff (rst)
        (slot == LAST) |=> (slot == '0));

endmodule

// File: rtl/hub_lane_steer.sv
module hub_lane_steer
    import hub_pkg::*;
#(
    parameter int BANK_SEL_W = 4,
    parameter int ROW_W      = 6,
    localparam int BANKS     = 1 << BANK_SEL_W,
    localparam int ROW_LSB   = 2 + BANK_SEL_W,
    localparam int ADDR_W    = ROW_LSB + ROW_W,
    localparam int LINE_W    = 32 * BANKS
) (
    input  op_e                          op,
    input  xfer_size_e                   size,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [LINE_W-1:0]            wdata,
    output logic [BANKS-1:0]             bank_en,
    output logic [BANKS-1:0][3:0]        bank_we,
    output logic [BANKS-1:0][31:0]       bank_wd,
    output logic [ROW_W-1:0]             row,
    output logic [BANK_SEL_W-1:0]        lane_bank,
    output logic [1:0]                   lane_off
);
    logic [1:0]  raw_off;
    logic [3:0]  lane_be;
    logic [31:0] lane_data;

    assign row       = addr[ADDR_W-1:ROW_LSB];
    assign lane_bank = addr[ROW_LSB-1:2];
    assign raw_off   = addr[1:0];

    // alignment and lane replication by size
    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                lane_off  = raw_off;
                lane_be   = 4'b0001 << raw_off;
                lane_data = {4{wdata[7:0]}};
            end
            SZ_WORD: begin
                lane_off  = {raw_off[1], 1'b0};
                lane_be   = raw_off[1] ? 4'b1100 : 4'b0011;
                lane_data = {2{wdata[15:0]}};
            end
            default: begin
                lane_off  = 2'b00;
                lane_be   = 4'b1111;
                lane_data = wdata[31:0];
            end
        endcase
    end

    // bank enables and write strobes by operation
    always_comb begin
        bank_en = '0;
        bank_we = '0;
        bank_wd = '0;
        unique case (op)
            OP_IDLE: begin
            end
            OP_RD_NARROW: begin
                bank_en[lane_bank] = 1'b1;
            end
            OP_WR_NARROW: begin
                bank_en[lane_bank] = 1'b1;
                bank_we[lane_bank] = lane_be;
                for (int b = 0; b < BANKS; b++)
                    bank_wd[b] = lane_data;
            end
            OP_RD_BLOCK: begin
                bank_en = '1;
            end
            OP_WR_BLOCK: begin
                bank_en = '1;
                for (int b = 0; b < BANKS; b++) begin
                    bank_we[b] = 4'b1111;
                    bank_wd[b] = wdata[32*b +: 32];
                end
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/hub_bank.sv
module hub_bank #(
    parameter int ROW_W = 6,
    localparam int DEPTH = 1 << ROW_W
) (
    input  logic             clk,
    input  logic             en,
    input  logic [3:0]       we,
    input  logic [ROW_W-1:0] row,
    input  logic [31:0]      wd,
    output logic [31:0]      q
);
    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            for (int i = 0; i < 4; i++)
                if (we[i])
                    mem[row][8*i +: 8] <= wd[8*i +: 8];
            if (we == 4'b0000)
                q <= mem[row];
        end
    end

endmodule

// File: rtl/hub_slot_mem.sv
module hub_slot_mem
    import hub_pkg::*;
#(
    parameter int CLIENTS    = 16,
    parameter int BANK_SEL_W = 4,
    parameter int ROW_W      = 6,
    localparam int SLOT_W    = $clog2(CLIENTS),
    localparam int BANKS     = 1 << BANK_SEL_W,
    localparam int ROW_LSB   = 2 + BANK_SEL_W,
    localparam int ADDR_W    = ROW_LSB + ROW_W,
    localparam int LINE_W    = 32 * BANKS
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [CLIENTS-1:0]          req_valid,
    input  logic [CLIENTS-1:0]          req_write,
    input  logic [2*CLIENTS-1:0]        req_size,
    input  logic [ADDR_W*CLIENTS-1:0]   req_addr,
    input  logic [LINE_W*CLIENTS-1:0]   req_wdata,
    output logic [CLIENTS-1:0]          req_stall,
    output logic [CLIENTS-1:0]          rsp_valid,
    output logic [LINE_W-1:0]           rsp_data
);
    logic [SLOT_W-1:0] slot;

    logic [CLIENTS-1:0][1:0]        size_v;
    logic [CLIENTS-1:0][ADDR_W-1:0] addr_v;
    logic [CLIENTS-1:0][LINE_W-1:0] wdata_v;

    assign size_v  = req_size;
    assign addr_v  = req_addr;
    assign wdata_v = req_wdata;

    logic              sel_valid;
    logic              sel_write;
    xfer_size_e        sel_size;
    logic [ADDR_W-1:0] sel_addr;
    logic [LINE_W-1:0] sel_wdata;
    op_e               op;

    logic [BANKS-1:0]        bank_en;
    logic [BANKS-1:0][3:0]   bank_we;
    logic [BANKS-1:0][31:0]  bank_wd;
    logic [BANKS-1:0][31:0]  bank_q;
    logic [ROW_W-1:0]        row;
    logic [BANK_SEL_W-1:0]   lane_bank;
    logic [1:0]              lane_off;

    rsp_state_e              rsp_state, rs_next;
    logic [SLOT_W-1:0]       rsp_owner;
    logic [BANK_SEL_W-1:0]   rsp_bank;
    logic [1:0]              rsp_off;
    xfer_size_e              rsp_size;
    logic [31:0]             long_sel, long_shift, narrow_val;

    hub_slot_ctr #(.CLIENTS(CLIENTS)) u_slot (
        .clk  (clk),
        .rst  (rst),
        .slot (slot)
    );

    // stall for every requester that is not the owner
    for (genvar c = 0; c < CLIENTS; c++) begin : g_stall
        assign req_stall[c] = req_valid[c] && (slot != SLOT_W'(c));
    end

    // owner's request
    always_comb begin
        sel_valid = req_valid[slot];
        sel_write = req_write[slot];
        sel_size  = xfer_size_e'(size_v[slot]);
        sel_addr  = addr_v[slot];
        sel_wdata = wdata_v[slot];
    end

    // per-cycle access decode
    always_comb begin
        op = OP_IDLE;
        if (sel_valid) begin
            unique case (sel_size)
                SZ_BLOCK: op = sel_write ? OP_WR_BLOCK  : OP_RD_BLOCK;
                default:  op = sel_write ? OP_WR_NARROW : OP_RD_NARROW;
            endcase
        end
    end

    hub_lane_steer #(.BANK_SEL_W(BANK_SEL_W), .ROW_W(ROW_W)) u_steer (
        .op        (op),
        .size      (sel_size),
        .addr      (sel_addr),
        .wdata     (sel_wdata),
        .bank_en   (bank_en),
        .bank_we   (bank_we),
        .bank_wd   (bank_wd),
        .row       (row),
        .lane_bank (lane_bank),
        .lane_off  (lane_off)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        hub_bank #(.ROW_W(ROW_W)) u_bank (
            .clk (clk),
            .en  (bank_en[b]),
            .we  (bank_we[b]),
            .row (row),
            .wd  (bank_wd[b]),
            .q   (bank_q[b])
        );
    end

    // response next-state
    always_comb begin
        unique case (op)
            OP_RD_NARROW: rs_next = RS_NARROW;
            OP_RD_BLOCK:  rs_next = RS_BLOCK;
            default:      rs_next = RS_NONE;
        endcase
    end

    // response state register
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_state <= RS_NONE;
            rsp_owner <= '0;
            rsp_bank  <= '0;
            rsp_off   <= '0;
            rsp_size  <= SZ_BYTE;
        end else begin
            rsp_state <= rs_next;
            rsp_owner <= slot;
            rsp_bank  <= lane_bank;
            rsp_off   <= lane_off;
            rsp_size  <= sel_size;
        end
    end

    // narrow lane extraction
    always_comb begin
        long_sel   = bank_q[rsp_bank];
        long_shift = long_sel >> {rsp_off, 3'b000};
        unique case (rsp_size)
            SZ_BYTE: narrow_val = {24'b0, long_shift[7:0]};
            SZ_WORD: narrow_val = {16'b0, long_shift[15:0]};
            default: narrow_val = long_sel;
        endcase
    end

    // response outputs
    always_comb begin
        rsp_valid = '0;
        rsp_data  = '0;
        unique case (rsp_state)
            RS_NONE: begin
            end
            RS_NARROW: begin
                rsp_valid[rsp_owner] = 1'b1;
                rsp_data[31:0]       = narrow_val;
            end
            RS_BLOCK: begin
                rsp_valid[rsp_owner] = 1'b1;
                rsp_data             = bank_q;
            end
            default: begin
            end
        endcase
    end

    // R8: narrow touches one bank, block touches all
    a_r8_narrow_one_bank: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RD_NARROW || op == OP_WR_NARROW) |-> ($countones(bank_en) == 1));
    a_r8_block_all_banks: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RD_BLOCK || op == OP_WR_BLOCK) |-> (&bank_en));
    // R7: word lanes stay even
    a_r7_word_even: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RD_NARROW && sel_size == SZ_WORD) |-> (lane_off[0] == 1'b0));
    // R2: a read yields exactly one valid in the following clock
    a_r2_read_answers: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RD_NARROW || op == OP_RD_BLOCK) |=> ($countones(rsp_valid) == 1));
    a_r2_valid_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rsp_valid));
    // R10: writes and idle slots never answer
    a_r10_quiet_otherwise: assert property (@(posedge clk) disable iff (rst)
        (op == OP_IDLE || op == OP_WR_NARROW || op == OP_WR_BLOCK) |=> (rsp_valid == '0));

endmodule

// File: tb/sim_hub_slot_mem.sv
module sim_hub_slot_mem;
    localparam int CLIENTS    = 16;
    localparam int BANK_SEL_W = 4;
    localparam int ROW_W      = 6;
    localparam int BANKS      = 1 << BANK_SEL_W;
    localparam int ROW_LSB    = 2 + BANK_SEL_W;
    localparam int ADDR_W     = ROW_LSB + ROW_W;
    localparam int LINE_W     = 32 * BANKS;
    localparam int NLONG      = BANKS << ROW_W;
    localparam int ROWS       = 1 << ROW_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [CLIENTS-1:0]        req_valid = '0;
    logic [CLIENTS-1:0]        req_write = '0;
    logic [2*CLIENTS-1:0]      req_size  = '0;
    logic [ADDR_W*CLIENTS-1:0] req_addr  = '0;
    logic [LINE_W*CLIENTS-1:0] req_wdata = '0;
    logic [CLIENTS-1:0]        req_stall;
    logic [CLIENTS-1:0]        rsp_valid;
    logic [LINE_W-1:0]         rsp_data;

    hub_slot_mem #(.CLIENTS(CLIENTS), .BANK_SEL_W(BANK_SEL_W), .ROW_W(ROW_W)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_stall(req_stall), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    always #5 clk = ~clk;

    int unsigned slot_cnt;
    always @(posedge clk) begin
        if (rst) slot_cnt <= 0;
        else     slot_cnt <= slot_cnt + 1;
    end

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [31:0]        model [NLONG];
    logic [CLIENTS-1:0] exp_rv = '0;
    logic [LINE_W-1:0]  exp_rd = '0;
    string              exp_tag = "R3";
    int                 fill_row = 0;
    int                 dir_idx  = 0;

    task automatic chk(input string tag, input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [LINE_W-1:0] rand_line();
        logic [LINE_W-1:0] r;
        for (int i = 0; i < BANKS; i++) r[32*i +: 32] = $urandom;
        return r;
    endfunction

    task automatic check_rsp();
        // R2 R10: valid only for the client whose read was served
        chk("R2 R10 rsp_valid", LINE_W'(rsp_valid), LINE_W'(exp_rv));
        if (exp_rv != '0) chk(exp_tag, rsp_data, exp_rd);
    endtask

    // mode 0: block-write fill, 1: random, 2: directed corners
    task automatic step(input int mode, input bit wait_edge);
        int s;
        logic v, wr;
        logic [1:0] sz, off;
        logic [ADDR_W-1:0] a;
        logic [LINE_W-1:0] wd;
        int idx, base;
        if (wait_edge) @(negedge clk);
        check_rsp();
        s = int'(slot_cnt % CLIENTS);
        for (int c = 0; c < CLIENTS; c++) begin
            req_valid[c]               = 1'($urandom_range(0, 1));
            req_write[c]               = 1'($urandom_range(0, 1));
            req_size[2*c +: 2]         = 2'($urandom_range(0, 3));
            req_addr[c*ADDR_W +: ADDR_W] = ADDR_W'($urandom);
            req_wdata[c*LINE_W +: LINE_W] = rand_line();
        end
        if (mode == 0) begin
            req_valid[s] = 1'b1; req_write[s] = 1'b1; req_size[2*s +: 2] = 2'd3;
            req_addr[s*ADDR_W +: ADDR_W] = {ROW_W'(fill_row), 6'($urandom)};
            fill_row++;
        end else if (mode == 1) begin
            req_valid[s] = ($urandom_range(0, 3) != 0);
        end else begin
            req_valid[s] = 1'b1;
            case (dir_idx)
                0: begin req_write[s] = 1; req_size[2*s +: 2] = 2'd0; req_addr[s*ADDR_W +: ADDR_W] = 12'h047; req_wdata[s*LINE_W +: 8]  = 8'hA5; end
                1: begin req_write[s] = 0; req_size[2*s +: 2] = 2'd2; req_addr[s*ADDR_W +: ADDR_W] = 12'h044; end
                2: begin req_write[s] = 1; req_size[2*s +: 2] = 2'd1; req_addr[s*ADDR_W +: ADDR_W] = 12'h047; req_wdata[s*LINE_W +: 16] = 16'hBEEF; end
                3: begin req_write[s] = 0; req_size[2*s +: 2] = 2'd0; req_addr[s*ADDR_W +: ADDR_W] = 12'h046; end
                4: begin req_write[s] = 0; req_size[2*s +: 2] = 2'd3; req_addr[s*ADDR_W +: ADDR_W] = 12'h07F; end
                5: begin req_write[s] = 1; req_size[2*s +: 2] = 2'd2; req_addr[s*ADDR_W +: ADDR_W] = 12'hFFF; req_wdata[s*LINE_W +: 32] = 32'h1234_5678; end
                default: begin req_write[s] = 0; req_size[2*s +: 2] = 2'd3; req_addr[s*ADDR_W +: ADDR_W] = 12'hFC5; end
            endcase
            dir_idx++;
        end
        #1;
        // R1 (and R9 on the first slot): stall for every non-owner requester
        for (int c = 0; c < CLIENTS; c++) begin
            chk(slot_cnt == 0 ? "R1 R9 stall" : "R1 stall",
                LINE_W'(req_stall[c]), LINE_W'(req_valid[c] && (c != s)));
        end
        // reference model of the owner's access
        v = req_valid[s]; wr = req_write[s]; sz = req_size[2*s +: 2];
        a = req_addr[s*ADDR_W +: ADDR_W]; wd = req_wdata[s*LINE_W +: LINE_W];
        exp_rv = '0;
        if (v) begin
            idx  = int'(a[ADDR_W-1:2]);
            off  = a[1:0];
            base = int'(a[ADDR_W-1:ROW_LSB]) * BANKS;
            if (wr) begin
                case (sz)
                    2'd0: model[idx][8*off +: 8] = wd[7:0];          // R4
                    2'd1: model[idx][16*off[1] +: 16] = wd[15:0];    // R4 R7
                    2'd2: model[idx] = wd[31:0];                     // R7
                    default: for (int b = 0; b < BANKS; b++) model[base + b] = wd[32*b +: 32]; // R6
                endcase
            end else begin
                exp_rv[s] = 1'b1;
                exp_rd    = '0;
                if (sz == 2'd3) begin
                    exp_tag = "R5 R6 R8 block read";
                    for (int b = 0; b < BANKS; b++) exp_rd[32*b +: 32] = model[base + b];
                end else begin
                    exp_tag = "R3 R4 R7 narrow read";
                    case (sz)
                        2'd0:    exp_rd[7:0]  = model[idx][8*off +: 8];
                        2'd1:    exp_rd[15:0] = model[idx][16*off[1] +: 16];
                        default: exp_rd[31:0] = model[idx];
                    endcase
                end
            end
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NLONG; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        // R9: nothing answers during reset
        chk("R9 rsp_valid in reset", LINE_W'(rsp_valid), '0);
        chk("R9 stall in reset", LINE_W'(req_stall), '0);
        rst = 1'b0;
        step(0, 1'b0);
        for (int r = 1; r < ROWS; r++) step(0, 1'b1);
        for (int d = 0; d < 7; d++) step(2, 1'b1);
        for (int n = 0; n < 3000; n++) step(1, 1'b1);
        @(negedge clk);
        check_rsp();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end

    initial begin
        #1_900_000;
        if (!done) begin
            total++;
            fails++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
            $finish;
        end
    end

endmodule